// File: doc/BRIEF.md
# Cache-Enable / Invalidate Pin Driver

This block drives one host-bus pin that serves two purposes at different times. While the CPU runs a read cycle, the pin tells the CPU whether the line being fetched may be placed in its first-level cache. A low level means cache it. A high level means do not. While the system snoops the CPU cache on behalf of a PCI master, the same pin tells the cache whether to invalidate the snooped line. A high level invalidates it. A low level keeps it.

For a CPU cycle, the block samples the cycle type at the CPU cycle strobe. It samples the burst request, the cacheability decision for the address and the cache-enable configuration bit at the same strobe. It commits its answer on the first next-address or burst-ready strobe of that cycle, whichever comes first. It holds that level until the cycle ends.

During a snoop address strobe, the pin follows the direction of the PCI transfer. The configuration bit has no effect on the snoop answer. The pin rests low whenever neither role is active.

Top module: `kinv_driver`

## Requirements
- R1: After reset, and whenever no CPU cycle response is held and no snoop strobe is present, `pin_out` is 0.
- R2: On a CPU read whose latched state is not cacheable, `pin_out` is 1 during the first response strobe. The first response strobe is `nxt_addr` or `brdy` while a cycle is active. A read is non-cacheable when it is an I/O read, or the address was not cacheable, or there was no burst request.
- R3: On a cacheable CPU read, `pin_out` is 0 during the first response strobe. A cacheable read has `cyc_is_mem`=1, `cyc_is_read`=1, `burst_req`=1, `addr_cacheable`=1 and `l1_enable`=1, all sampled at `cyc_strobe`.
- R4: If `nxt_addr` arrives before the first `brdy`, the level is committed at `nxt_addr`. The later `brdy` pulses leave it unchanged.
- R5: During `snp_strobe` with `snp_is_write`=1, `pin_out` is 1.
- R6: During `snp_strobe` with `snp_is_write`=0, `pin_out` is 0.
- R7: The snoop-time level does not depend on `l1_enable`.
- R8: When `l1_enable`=0 at `cyc_strobe`, every CPU read is treated as non-cacheable, so `pin_out` is 1 at its first response.
- R9: The cycle type, burst request, cacheability decision and `l1_enable` are latched at `cyc_strobe`. Changes to them later in the cycle have no effect on `pin_out`.
- R10: After the first response, `pin_out` holds the committed level on every following cycle of the CPU cycle, including the `cyc_done` cycle.
- R11: `pin_out` returns to 0 in the clock after a snoop strobe, and in the clock after `cyc_done`.
- R12: CPU write cycles (`cyc_is_read`=0) keep `pin_out` at 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strobe | input | 1 | CPU cycle start strobe |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O |
| cyc_is_read | input | 1 | 1 = read, 0 = write |
| burst_req | input | 1 | CPU requests a burst line transfer |
| addr_cacheable | input | 1 | Address decode says the line is cacheable |
| l1_enable | input | 1 | First-level cache-enable configuration bit |
| brdy | input | 1 | Burst-ready strobe |
| nxt_addr | input | 1 | Next-address strobe |
| cyc_done | input | 1 | Last clock of the CPU cycle |
| snp_strobe | input | 1 | Snoop address strobe for a PCI master |
| snp_is_write | input | 1 | 1 = PCI master writes DRAM, 0 = reads |
| pin_out | output | 1 | Multiplexed pin level |

## Verification
The embedded assertions check the following on every clock:
- the resting low level when idle;
- both snoop polarities, whatever the configuration bit is;
- the release one clock after a snoop;
- the stability of the committed level across later burst-ready pulses.

Only the bench scenarios can show the correct cacheability answer for each combination of cycle type, burst request, address decision and configuration bit. They also show that inputs changed after the cycle strobe are ignored, and which of next-address or burst-ready commits the answer.

// File: rtl/kinv_pkg.sv
package kinv_pkg;
   typedef struct packed {
      logic is_mem;
      logic is_read;
      logic burst;
      logic cacheable;
      logic l1en;
   } cyc_info_t;
   localparam int unsigned CYC_INFO_W = $bits(cyc_info_t);
endpackage

// File: rtl/kinv_cycle_tracker.sv
module kinv_cycle_tracker
   import kinv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cyc_strobe,
   input  logic      cyc_done,
   input  logic      resp_any,
   input  cyc_info_t info_in,
   output logic      active,
   output logic      committed,
   output logic      first_resp,
   output cyc_info_t info_q
);
   assign first_resp = active & resp_any & ~committed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         committed <= 1'b0;
         info_q    <= '0;
      end else begin
         if (cyc_strobe) begin
            active    <= 1'b1;
            committed <= 1'b0;
            info_q    <= info_in;   // R9 latch at strobe
         end else if (cyc_done) begin
            active    <= 1'b0;
            committed <= 1'b0;
         end else if (first_resp) begin
            committed <= 1'b1;
         end
      end
   end

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      committed && !cyc_strobe && !cyc_done |=> committed) else $error("commit lost"); // R4
endmodule

// File: rtl/kinv_ken_decide.sv
module kinv_ken_decide
   import kinv_pkg::*;
#(
   parameter bit BURST_GATES_KEN = 1'b1
)(
   input  cyc_info_t info,
   output logic      level
);
   logic cacheable_rd;
   // R3/R8: cacheable only with enable bit, memory read and cacheable address
   assign cacheable_rd = info.is_mem & info.is_read & info.cacheable & info.l1en
                         & (info.burst | ~BURST_GATES_KEN);
   // R2 high for non-cacheable reads, R12 writes rest low
   assign level = info.is_read & ~cacheable_rd;
endmodule

// File: rtl/kinv_driver.sv
module kinv_driver
   import kinv_pkg::*;
#(
   parameter bit BURST_GATES_KEN = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_strobe,
   input  logic cyc_is_mem,
   input  logic cyc_is_read,
   input  logic burst_req,
   input  logic addr_cacheable,
   input  logic l1_enable,
   input  logic brdy,
   input  logic nxt_addr,
   input  logic cyc_done,
   input  logic snp_strobe,
   input  logic snp_is_write,
   output logic pin_out
);
   initial begin
      if (CYC_INFO_W != 5) $error("cycle info width mismatch");
   end

   cyc_info_t info_in, info_q;
   logic active, committed, first_resp, level, held;

   assign info_in = '{is_mem: cyc_is_mem, is_read: cyc_is_read, burst: burst_req,
                      cacheable: addr_cacheable, l1en: l1_enable};

   kinv_cycle_tracker u_trk (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cyc_done(cyc_done),
      .resp_any(brdy | nxt_addr), .info_in(info_in), .active(active),
      .committed(committed), .first_resp(first_resp), .info_q(info_q));

   kinv_ken_decide #(.BURST_GATES_KEN(BURST_GATES_KEN)) u_dec (
      .info(info_q), .level(level));

   always_ff @(posedge clk) begin
      if (!rst_n)                   held <= 1'b0;
      else if (cyc_strobe || cyc_done) held <= 1'b0;
      else if (first_resp)          held <= level;
   end

   always_comb begin
      if (snp_strobe)                 pin_out = snp_is_write;   // R5 R6 R7
      else if (first_resp)            pin_out = level;          // R2 R3 R4
      else if (active && committed)   pin_out = held;           // R10
      else                            pin_out = 1'b0;           // R1 R11
   end

   AST_SNOOP_WR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      snp_strobe && snp_is_write |-> pin_out) else $error("snoop write"); // R5
   AST_SNOOP_RD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      snp_strobe && !snp_is_write |-> !pin_out) else $error("snoop read"); // R6
   AST_SNOOP_CFG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      snp_strobe && !l1_enable |-> pin_out == snp_is_write) else $error("snoop cfg"); // R7
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !snp_strobe |-> !pin_out) else $error("idle level"); // R1
   AST_SNOOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snp_strobe) && !snp_strobe && !active |-> !pin_out) else $error("release"); // R11
   AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      active && committed && $past(active && committed) && !snp_strobe
      && !$past(snp_strobe) && !$past(cyc_strobe) |-> $stable(pin_out)) else $error("hold"); // R10
endmodule

// File: tb/sim_kinv_driver.sv
module sim_kinv_driver;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cyc_strobe = 0, cyc_is_mem = 0, cyc_is_read = 0, burst_req = 0;
   logic addr_cacheable = 0, l1_enable = 0, brdy = 0, nxt_addr = 0, cyc_done = 0;
   logic snp_strobe = 0, snp_is_write = 0;
   logic pin_out;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   kinv_driver u0 (.*);

   // {mem, read, burst, cacheable, l1en, na_first, expected}
   localparam logic [6:0] VEC [10] = '{
      7'b11111_0_0, 7'b11111_1_0, 7'b11101_0_1, 7'b11011_1_1, 7'b11110_0_1,
      7'b01111_0_1, 7'b10111_0_0, 7'b10001_1_0, 7'b11000_1_1, 7'b00111_1_0 };

   task automatic chk(input logic exp, input string req);
      checks++;
      if (pin_out !== exp) begin
         fails++;
         $display("FAIL %s: pin_out=%b expected %b at %0t", req, pin_out, exp, $time);
      end
   endtask

   task automatic tick;
      @(negedge clk);
      cyc_strobe = 0; brdy = 0; nxt_addr = 0; cyc_done = 0; snp_strobe = 0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 chk(1'b0, "R1 reset");
      rst_n = 1;
      tick; #1 chk(1'b0, "R1 idle");
      for (int i = 0; i < 10; i++) begin
         tick;
         {cyc_is_mem, cyc_is_read, burst_req, addr_cacheable, l1_enable} = VEC[i][6:2];
         cyc_strobe = 1;
         #1 chk(1'b0, "R1 strobe");
         tick;
         {cyc_is_mem, cyc_is_read, burst_req, addr_cacheable, l1_enable} = ~VEC[i][6:2]; // R9
         #1 chk(1'b0, "R1 wait");
         tick;
         if (VEC[i][1]) nxt_addr = 1; else brdy = 1;
         #1 chk(VEC[i][0], "R2/R3/R8/R9/R12 first response");
         tick; brdy = 1;
         #1 chk(VEC[i][0], "R4 later brdy");
         tick; brdy = 1;
         {cyc_is_mem, cyc_is_read, burst_req, addr_cacheable, l1_enable} = VEC[i][6:2];
         #1 chk(VEC[i][0], "R10 hold");
         tick; cyc_done = 1;
         #1 chk(VEC[i][0], "R10 done cycle");
         tick;
         #1 chk(1'b0, "R11 after done");
      end
      for (int k = 0; k < 4; k++) begin
         tick; snp_strobe = 1; snp_is_write = k[0]; l1_enable = k[1];
         #1 chk(k[0], k[0] ? "R5 R7 snoop write" : "R6 R7 snoop read");
         tick;
         #1 chk(1'b0, "R11 snoop release");
      end
      // snoop during held CPU answer, then release back to held level
      tick; {cyc_is_mem, cyc_is_read, burst_req, addr_cacheable, l1_enable} = 5'b11001;
      cyc_strobe = 1;
      tick; nxt_addr = 1; #1 chk(1'b1, "R2 io/noncache");
      tick; snp_strobe = 1; snp_is_write = 0; #1 chk(1'b0, "R6 snoop priority");
      tick; #1 chk(1'b1, "R10 held after snoop");
      tick; cyc_done = 1;
      tick; #1 chk(1'b0, "R11 end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule